// File: doc/BRIEF.md
# In-Place Radix-2 FFT Engine

This block computes a complex discrete Fourier transform of N points (N a power of two, default 1024) in place in one RAM. An I/O port fills the RAM with complex samples, a start pulse launches the transform, and the same port reads the spectrum back. A single butterfly unit works through the stages one after another. Each butterfly reads two points, multiplies the lower point by a twiddle factor, forms the sum and the difference, halves both and writes them back to the addresses they came from.

Each RAM word holds a complex value as two 16-bit two's-complement halves. The twiddle factors are Q14 fixed point and are computed at elaboration from the transform length. Samples are stored at bit-reversed addresses as they are loaded, so spectrum bin k is read at address k. Because every stage halves its results, the output is the true transform divided by N.

The controller has four states. ST_IO is the idle state, and the I/O port owns the RAM. ST_READ presents the two butterfly addresses to the RAM. ST_WRITE applies the butterfly and writes both results. ST_FINISH is a single cycle that raises the completion pulse. The transitions are: ST_IO to ST_READ on start; ST_READ to ST_WRITE always; ST_WRITE to ST_READ while butterflies remain; ST_WRITE to ST_FINISH after the last butterfly of the last stage; ST_FINISH to ST_IO always.

Top module: `fft_engine`

## Requirements
- R1: After reset, busy and done are both 0 and the engine is in the I/O state.
- R2: An I/O write of sample index n with io_wr_en stores the word at the address whose log2(N) bits are those of n in reverse order.
- R3: An I/O read drives io_rdata on the cycle after io_rd_en, with the word at address io_addr taken in natural order. Bits [31:16] of a word are the real part and bits [15:0] the imaginary part, both two's complement.
- R4: A start pulse sampled while idle sets busy. done is high for exactly one cycle, on the cycle after the (N·log2(N))-th rising edge that follows the edge which sampled start. busy stays high until that cycle and is 0 on the next cycle.
- R5: A constant real input v gives v in bin 0 and exactly 0 in every other bin, because each of the log2(N) stages halves its results.
- R6: For any input, bin k equals (1/N)·Σ x[n]·e^(−j2πkn/N) within ±3 LSB per part, read in natural order.
- R7: While busy, io_wr_en, io_rd_en and further start pulses have no effect on the RAM contents or on the schedule.
- R8: Once done has been given, the I/O port controls the RAM again, so new data can be loaded and a second transform run at once.
- R9: Imaginary input is processed like real input: a constant imaginary value v gives bin 0 equal to 0 + j·v exactly, with every other bin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr_en | input | 1 | Write io_wdata for sample index io_addr (idle only) |
| io_rd_en | input | 1 | Read the RAM word at io_addr (idle only) |
| io_addr | input | log2(N) | Sample index for writes, bin index for reads |
| io_wdata | input | 32 | Complex sample: real in [31:16], imaginary in [15:0] |
| io_rdata | output | 32 | Word read on the previous cycle |
| start | input | 1 | Launch a transform (idle only) |
| busy | output | 1 | Transform in progress; the RAM belongs to the butterfly |
| done | output | 1 | One-cycle completion pulse |

## Verification
The transform is driven with a real constant and with an imaginary constant. Both must come out exactly, which separates a correct per-stage halving and twiddle for index 0 from an off-by-one scaling, and catches real and imaginary parts being swapped. An impulse at index 0 spreads energy into every bin, and a complex tone in bin 3 has a single peak. Together they show whether the twiddle sign, the twiddle index step and the bit-reversed loading are right, since a conjugated or misindexed twiddle moves the peak. An irregular mixed pattern is compared against a floating-point transform computed in the bench. The load-and-read-back test, the ignored-write test and the back-to-back test check the address ordering, the bus hand-over and the cycle count.

// File: rtl/fft_pkg.sv
package fft_pkg;

    localparam int DATA_W  = 16;
    localparam int TW_FRAC = 14;
    localparam int SMAX    = (1 << (DATA_W - 1)) - 1;
    localparam int SMIN    = -(1 << (DATA_W - 1));

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        ST_IO     = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } ctrl_state_t;

    // pi and 1.0 scaled by 2^30
    localparam longint PI_Q30  = 64'sd3373259426;
    localparam longint ONE_Q30 = 64'sd1073741824;

    // Twiddle W^k = cos(2*pi*k/n) - j*sin(2*pi*k/n) in Q14, for 0 <= k < n/2.
    // Evaluated at elaboration by a Taylor series on [0, pi/2].
    function automatic cplx_t twiddle_at(input int k, input int n);
        longint th;
        longint x2;
        longint term;
        longint c;
        longint s;
        longint cr;
        longint sr;
        logic   mirror;
        cplx_t  w;
        th = (longint'(2) * PI_Q30 * longint'(k)) / longint'(n);
        mirror = 1'b0;
        if (th > PI_Q30 / 2) begin
            th = PI_Q30 - th;
            mirror = 1'b1;
        end
        x2   = (th * th) >>> 30;
        c    = ONE_Q30;
        term = ONE_Q30;
        for (int i = 1; i <= 9; i++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * i - 1) * (2 * i)));
            c    = c + term;
        end
        s    = th;
        term = th;
        for (int i = 1; i <= 9; i++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * i) * (2 * i + 1)));
            s    = s + term;
        end
        if (mirror) begin
            c = -c;
        end
        cr   = (c + 64'sd32768) >>> 16;
        sr   = -((s + 64'sd32768) >>> 16);
        w.re = cr[DATA_W-1:0];
        w.im = sr[DATA_W-1:0];
        return w;
    endfunction

    // Round a Q14 product sum to integer units.
    function automatic int tw_round(input int p);
        return (p + (1 << (TW_FRAC - 1))) >>> TW_FRAC;
    endfunction

    // Halve and clamp to the 16-bit signed range.
    function automatic logic signed [DATA_W-1:0] sat_half(input int v);
        int h;
        h = v >>> 1;
        if (h > SMAX) begin
            h = SMAX;
        end else if (h < SMIN) begin
            h = SMIN;
        end
        return h[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/fft_dpram.sv
module fft_dpram #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] addr_a,
    input  logic          we_a,
    input  logic          re_a,
    input  logic [DW-1:0] wdata_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] addr_b,
    input  logic          we_b,
    input  logic          re_b,
    input  logic [DW-1:0] wdata_b,
    output logic [DW-1:0] rdata_b
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) begin
            mem[addr_a] <= wdata_a;
        end
        if (we_b) begin
            mem[addr_b] <= wdata_b;
        end
        if (re_a) begin
            rdata_a <= mem[addr_a];
        end
        if (re_b) begin
            rdata_b <= mem[addr_b];
        end
    end

endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
    parameter int AW = 10,
    parameter int SW = 4
) (
    input  logic [SW-1:0] stage,
    input  logic [AW-2:0] bf_idx,
    output logic [AW-1:0] addr_top,
    output logic [AW-1:0] addr_bot,
    output logic [AW-2:0] tw_idx
);

    localparam int PW = AW - 1;

    logic [PW-1:0] low_mask;
    logic [PW-1:0] pos;
    logic [PW-1:0] grp;

    always_comb begin
        // positions below the stage's span index within a group
        low_mask = {PW{1'b1}} >> (PW - int'(stage));
        pos      = bf_idx & low_mask;
        grp      = bf_idx & ~low_mask;
        // the group bits move up by one to make room for the pair bit
        addr_top = {grp, 1'b0} | {1'b0, pos};
        addr_bot = addr_top | (AW'(1) << stage);
        // twiddle step is N / 2^(stage+1)
        tw_idx   = pos << (PW - int'(stage));
    end

endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly
    import fft_pkg::*;
#(
    parameter int N    = 1024,
    parameter int TW_W = $clog2(N) - 1
) (
    input  cplx_t           a_in,
    input  cplx_t           b_in,
    input  logic [TW_W-1:0] tw_idx,
    output cplx_t           top_out,
    output cplx_t           bot_out
);

    localparam int TW_DEPTH = N / 2;

    cplx_t tw_rom [TW_DEPTH];
    cplx_t w;

    for (genvar g = 0; g < TW_DEPTH; g++) begin : g_tw
        localparam cplx_t TW_VAL = twiddle_at(g, N);
        assign tw_rom[g] = TW_VAL;
    end

    assign w = tw_rom[tw_idx];

    int t_re;
    int t_im;

    always_comb begin
        t_re = tw_round(int'(w.re) * int'(b_in.re) - int'(w.im) * int'(b_in.im));
        t_im = tw_round(int'(w.re) * int'(b_in.im) + int'(w.im) * int'(b_in.re));
        top_out.re = sat_half(int'(a_in.re) + t_re);
        top_out.im = sat_half(int'(a_in.im) + t_im);
        bot_out.re = sat_half(int'(a_in.re) - t_re);
        bot_out.im = sat_half(int'(a_in.im) - t_im);
    end

endmodule

// File: rtl/fft_ctrl.sv
module fft_ctrl
    import fft_pkg::*;
#(
    parameter int AW = 10,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [SW-1:0] stage,
    output logic [AW-2:0] bf_idx,
    output logic          fft_mode,
    output logic          rd_phase,
    output logic          wb_phase,
    output logic          done
);

    localparam logic [SW-1:0] LAST_STAGE = SW'(AW - 1);
    localparam logic [AW-2:0] LAST_BF    = '1;

    ctrl_state_t state_q;
    ctrl_state_t state_d;
    logic        last_bf;
    logic        last_stage;

    assign last_bf    = (bf_idx == LAST_BF);
    assign last_stage = (stage == LAST_STAGE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IO;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IO:     if (start) state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = (last_bf && last_stage) ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IO;
            default:   state_d = ST_IO;
        endcase
    end

    // schedule counters: butterfly index inside the stage, then stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage  <= '0;
            bf_idx <= '0;
        end else if (state_q == ST_IO) begin
            stage  <= '0;
            bf_idx <= '0;
        end else if (state_q == ST_WRITE) begin
            if (last_bf) begin
                bf_idx <= '0;
                stage  <= stage + SW'(1);
            end else begin
                bf_idx <= bf_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        fft_mode = 1'b0;
        rd_phase = 1'b0;
        wb_phase = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IO: begin
            end
            ST_READ: begin
                fft_mode = 1'b1;
                rd_phase = 1'b1;
            end
            ST_WRITE: begin
                fft_mode = 1'b1;
                wb_phase = 1'b1;
            end
            ST_FINISH: begin
                fft_mode = 1'b1;
                done     = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fft_engine.sv
module fft_engine
    import fft_pkg::*;
#(
    parameter int N = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_wr_en,
    input  logic                   io_rd_en,
    input  logic [$clog2(N)-1:0]   io_addr,
    input  logic [2*DATA_W-1:0]    io_wdata,
    output logic [2*DATA_W-1:0]    io_rdata,
    input  logic                   start,
    output logic                   busy,
    output logic                   done
);

    localparam int AW = $clog2(N);
    localparam int SW = $clog2(AW + 1);
    localparam int WW = 2 * DATA_W;

    logic [SW-1:0] stage;
    logic [AW-2:0] bf_idx;
    logic [AW-2:0] tw_idx;
    logic          fft_mode;
    logic          rd_phase;
    logic          wb_phase;
    logic [AW-1:0] bf_addr_top;
    logic [AW-1:0] bf_addr_bot;
    logic [AW-1:0] io_addr_rev;

    logic [AW-1:0] ram_addr_a;
    logic          ram_we_a;
    logic          ram_re_a;
    logic [WW-1:0] ram_wd_a;
    logic [WW-1:0] ram_rd_a;
    logic [WW-1:0] ram_rd_b;
    cplx_t         bf_top;
    cplx_t         bf_bot;

    for (genvar i = 0; i < AW; i++) begin : g_rev
        assign io_addr_rev[i] = io_addr[AW-1-i];
    end

    fft_ctrl #(.AW(AW), .SW(SW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stage    (stage),
        .bf_idx   (bf_idx),
        .fft_mode (fft_mode),
        .rd_phase (rd_phase),
        .wb_phase (wb_phase),
        .done     (done)
    );

    fft_addr_gen #(.AW(AW), .SW(SW)) agen_i (
        .stage    (stage),
        .bf_idx   (bf_idx),
        .addr_top (bf_addr_top),
        .addr_bot (bf_addr_bot),
        .tw_idx   (tw_idx)
    );

    fft_butterfly #(.N(N), .TW_W(AW - 1)) bfly_i (
        .a_in    (cplx_t'(ram_rd_a)),
        .b_in    (cplx_t'(ram_rd_b)),
        .tw_idx  (tw_idx),
        .top_out (bf_top),
        .bot_out (bf_bot)
    );

    // bus select: port A goes to the I/O side when idle, to the butterfly when busy
    always_comb begin
        if (fft_mode) begin
            ram_addr_a = bf_addr_top;
            ram_we_a   = wb_phase;
            ram_re_a   = rd_phase;
            ram_wd_a   = bf_top;
        end else begin
            ram_addr_a = io_wr_en ? io_addr_rev : io_addr;
            ram_we_a   = io_wr_en;
            ram_re_a   = io_rd_en & ~io_wr_en;
            ram_wd_a   = io_wdata;
        end
    end

    fft_dpram #(.AW(AW), .DW(WW)) ram_i (
        .clk     (clk),
        .addr_a  (ram_addr_a),
        .we_a    (ram_we_a),
        .re_a    (ram_re_a),
        .wdata_a (ram_wd_a),
        .rdata_a (ram_rd_a),
        .addr_b  (bf_addr_bot),
        .we_b    (wb_phase),
        .re_b    (rd_phase),
        .wdata_b (bf_bot),
        .rdata_b (ram_rd_b)
    );

    assign io_rdata = ram_rd_a;
    assign busy     = fft_mode;

endmodule

// File: rtl/fft_engine_chk.sv
module fft_engine_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          wb_phase,
    input logic [AW-1:0] addr_top,
    input logic [AW-1:0] addr_bot
);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R4
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phase |-> (addr_top != addr_bot));

    // R6
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phase |-> (addr_top < addr_bot));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!busy && !done));

endmodule

bind fft_engine fft_engine_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .wb_phase (wb_phase),
    .addr_top (bf_addr_top),
    .addr_bot (bf_addr_bot)
);

// File: tb/fft_engine_tb.sv
`timescale 1ns/1ps
module fft_engine_tb_top;

    localparam int    TN     = 16;
    localparam int    TAW    = 4;
    localparam int    EXP_CY = TN * TAW + 1;
    localparam real   TWO_PI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic        io_rd_en = 1'b0;
    logic [TAW-1:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        start = 1'b0;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_err    = 0;
    int xr [TN];
    int xi [TN];

    always #2 clk = ~clk;

    fft_engine #(.N(TN)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr_en (io_wr_en),
        .io_rd_en (io_rd_en),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .start    (start),
        .busy     (busy),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bitrev(input int v);
        int r = 0;
        for (int i = 0; i < TAW; i++) begin
            r = (r << 1) | ((v >> i) & 1);
        end
        return r;
    endfunction

    task automatic io_write(input int idx, input logic [31:0] w);
        @(negedge clk);
        io_wr_en = 1'b1;
        io_addr  = TAW'(idx);
        io_wdata = w;
        @(negedge clk);
        io_wr_en = 1'b0;
    endtask

    task automatic io_read(input int idx, output logic [31:0] w);
        @(negedge clk);
        io_rd_en = 1'b1;
        io_addr  = TAW'(idx);
        @(negedge clk);
        io_rd_en = 1'b0;
        w = io_rdata;
    endtask

    task automatic load_vec();
        for (int n = 0; n < TN; n++) begin
            io_write(n, {xr[n][15:0], xi[n][15:0]});
        end
    endtask

    // start one transform; returns edges from the start edge to done
    task automatic run_fft(input string req, output int cycles);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        @(negedge clk);
        check(!done && !busy, req, "done/busy after pulse", int'({done, busy}), 0);
    endtask

    task automatic check_spectrum(input string req, input real tol);
        logic [31:0] w;
        for (int k = 0; k < TN; k++) begin
            real sr = 0.0;
            real si = 0.0;
            int  ar;
            int  ai;
            for (int n = 0; n < TN; n++) begin
                real ang = TWO_PI * real'(k * n) / real'(TN);
                sr += real'(xr[n]) * $cos(ang) + real'(xi[n]) * $sin(ang);
                si += real'(xi[n]) * $cos(ang) - real'(xr[n]) * $sin(ang);
            end
            sr = sr / real'(TN);
            si = si / real'(TN);
            io_read(k, w);
            ar = int'($signed(w[31:16]));
            ai = int'($signed(w[15:0]));
            check((real'(ar) - sr <= tol) && (sr - real'(ar) <= tol), req,
                  $sformatf("bin %0d re", k), ar, $rtoi(sr + (sr < 0.0 ? -0.5 : 0.5)));
            check((real'(ai) - si <= tol) && (si - real'(ai) <= tol), req,
                  $sformatf("bin %0d im", k), ai, $rtoi(si + (si < 0.0 ? -0.5 : 0.5)));
        end
    endtask

    task automatic test_reset();
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    endtask

    task automatic test_load_order();
        logic [31:0] w;
        for (int n = 0; n < TN; n++) begin
            io_write(n, {16'(n), 16'(100 + n)});
        end
        for (int k = 0; k < TN; k++) begin
            io_read(k, w);
            check(int'(w[31:16]) == bitrev(k), "R2", $sformatf("addr %0d re", k),
                  int'(w[31:16]), bitrev(k));
            check(int'(w[15:0]) == 100 + bitrev(k), "R3", $sformatf("addr %0d im", k),
                  int'(w[15:0]), 100 + bitrev(k));
        end
    endtask

    task automatic test_dc_real();
        int cy;
        for (int n = 0; n < TN; n++) begin
            xr[n] = 12000;
            xi[n] = 0;
        end
        load_vec();
        run_fft("R4", cy);
        check(cy == EXP_CY, "R4", "cycles start to done", cy, EXP_CY);
        check_spectrum("R5", 0.01);
    endtask

    task automatic test_dc_imag();
        int cy;
        for (int n = 0; n < TN; n++) begin
            xr[n] = 0;
            xi[n] = -7000;
        end
        load_vec();
        run_fft("R9", cy);
        check_spectrum("R9", 0.01);
    endtask

    task automatic test_impulse();
        int cy;
        for (int n = 0; n < TN; n++) begin
            xr[n] = (n == 0) ? 16000 : 0;
            xi[n] = 0;
        end
        load_vec();
        run_fft("R6", cy);
        check_spectrum("R6", 3.0);
    endtask

    task automatic test_tone();
        int cy;
        for (int n = 0; n < TN; n++) begin
            real ang = TWO_PI * real'(3 * n) / real'(TN);
            xr[n] = $rtoi(8000.0 * $cos(ang) + 20000.5) - 20000;
            xi[n] = $rtoi(8000.0 * $sin(ang) + 20000.5) - 20000;
        end
        load_vec();
        run_fft("R6", cy);
        check_spectrum("R6", 3.0);
    endtask

    task automatic test_mixed();
        int cy;
        for (int n = 0; n < TN; n++) begin
            xr[n] = ((n * 1237) % 4001) - 2000;
            xi[n] = ((n * 733) % 3001) - 1500;
        end
        load_vec();
        run_fft("R6", cy);
        check_spectrum("R6", 3.0);
    endtask

    // I/O writes and start pulses issued mid-transform must change nothing
    task automatic test_ignore_busy();
        int cy;
        for (int n = 0; n < TN; n++) begin
            xr[n] = 5000;
            xi[n] = 0;
        end
        load_vec();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cy = 1;
        for (int i = 0; i < 12; i++) begin
            io_wr_en = 1'b1;
            io_rd_en = 1'b1;
            io_addr  = TAW'(i);
            io_wdata = 32'h7FFF_8000;
            start    = (i % 3 == 0);
            @(negedge clk);
            cy++;
        end
        io_wr_en = 1'b0;
        io_rd_en = 1'b0;
        start    = 1'b0;
        while (!done && cy < 1000) begin
            @(negedge clk);
            cy++;
        end
        check(cy == EXP_CY, "R7", "cycles with busy-time stimulus", cy, EXP_CY);
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy after done", int'(busy), 0);
        check_spectrum("R7", 0.01);
    endtask

    task automatic test_back_to_back();
        int cy;
        for (int n = 0; n < TN; n++) begin
            xr[n] = (n == 5) ? 8000 : 0;
            xi[n] = (n == 9) ? -4000 : 0;
        end
        load_vec();
        run_fft("R8", cy);
        check(cy == EXP_CY, "R8", "second run cycles", cy, EXP_CY);
        check_spectrum("R8", 3.0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_load_order();
        test_dc_real();
        test_dc_imag();
        test_impulse();
        test_tone();
        test_mixed();
        test_ignore_busy();
        test_back_to_back();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule